// File: doc/BRIEF.md
# Registered Parity Generator with Serial Shift

This block computes the odd parity of a twelve-bit data word and offers the result in two forms. The first is combinational: it goes high whenever an odd count of data bits is high, unless a force input pulls it low. The second is a one-bit register that is fed through two cascaded selectors. The register can keep its value, capture the current (gated) parity, or take an external serial bit, so several of these blocks can be chained into a parity scan path. Each output also comes with its complement.

The register has two tick inputs. Both are sampled on a free-running system clock, and the register advances only on the system cycle in which the OR of the two ticks is first seen high. A high level on the clear input empties the register at once, without waiting for the system clock. While clear is high, the register stays empty and the tick tracker is held armed-high. After clear is released, the OR of the ticks must therefore be seen low before an update can count.

Top module: `par_gen_reg`

## Requirements
- R1: With `force_low` low, `par` is 1 exactly when an odd number of the bits of `data_in` are 1 (bit i of `data_in` is data input i, all bits weighted alike).
- R2: With `force_low` high, `par` is 0 for any `data_in`.
- R3: `par_n` is always the inverse of `par`, and `par_reg_n` is always the inverse of `par_reg`.
- R4: On a qualified update with `shift_sel` low and `load_sel` low, `par_reg` keeps its value.
- R5: On a qualified update with `shift_sel` low and `load_sel` high, `par_reg` takes the gated `par` value of that cycle, so it captures 0 while `force_low` is high.
- R6: On a qualified update with `shift_sel` high, `par_reg` takes `ser_in`, whatever `load_sel` is.
- R7: An update qualifies on a rising edge of `clk` where `tick_a | tick_b` is sampled 1 after being sampled 0 on the previous edge. On every other edge `par_reg` is unchanged.
- R8: A tick that rises while the other tick is already high gives no update.
- R9: While `clr` is high, `par_reg` is 0. It goes to 0 as soon as `clr` rises, without waiting for `clk`, and it stays 0 through any ticks.
- R10: After `clr` falls, an update needs `tick_a | tick_b` to be sampled low at least once. A tick held high across the release does not update the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples the ticks |
| clr | input | 1 | Asynchronous active-high clear of the register |
| data_in | input | 12 | Data word whose parity is formed |
| force_low | input | 1 | High forces the combinational parity to 0 |
| load_sel | input | 1 | First selector: 1 loads parity, 0 keeps the register |
| shift_sel | input | 1 | Second selector: 1 takes the serial bit (overrides load_sel) |
| ser_in | input | 1 | Serial bit shifted in when shift_sel is high |
| tick_a | input | 1 | Register tick, first source |
| tick_b | input | 1 | Register tick, second source |
| par | output | 1 | Combinational gated odd parity |
| par_n | output | 1 | Complement of par |
| par_reg | output | 1 | Registered bit |
| par_reg_n | output | 1 | Complement of par_reg |

## Verification
The two functions most likely to collide are the asynchronous clear and a qualified tick update in the same system cycle, with a second tick rising while the first is still high as a related case. Random stimulus raises `clr` together with tick edges and selector settings. It also drives the two ticks independently, so overlapping highs and staggered rises occur often. A bench model judges each cycle. In that model clear always wins, the tracker is re-armed high, and only a low-to-high change of the OR counts as an update.

// File: rtl/par_gen_pkg.sv
package par_gen_pkg;

  localparam int unsigned PAR_DEF_WIDTH = 12;
  localparam int unsigned PAR_NUM_TICKS = 2;

  // which source feeds the register on a qualified update
  typedef enum logic [1:0] {
    SRC_KEEP  = 2'd0,
    SRC_LOAD  = 2'd1,
    SRC_SHIFT = 2'd2
  } reg_src_e;

  // the serial selector sits after the load selector, so it wins
  function automatic reg_src_e pick_src(input logic shift_sel, input logic load_sel);
    if (shift_sel)     return SRC_SHIFT;
    else if (load_sel) return SRC_LOAD;
    else               return SRC_KEEP;
  endfunction

  function automatic logic next_bit(input reg_src_e src, input logic cur,
                                    input logic par_v, input logic ser_v);
    case (src)
      SRC_SHIFT: return ser_v;
      SRC_LOAD:  return par_v;
      default:   return cur;
    endcase
  endfunction

  // gated parity, used where a plain loop form is wanted
  function automatic logic gate_par(input logic raw, input logic force_v);
    return raw & ~force_v;
  endfunction

endpackage

// File: rtl/par_xor_tree.sv
module par_xor_tree #(
  parameter int unsigned WIDTH = 12
) (
  input  logic [WIDTH-1:0] bits_in,
  output logic             odd_out
);
  localparam int unsigned LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
  localparam int unsigned LEAVES = 1 << LEVELS;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  // heap-ordered tree: node i has children 2i+1 and 2i+2
  logic [NODES-1:0] node;

  genvar gi;
  generate
    for (gi = 0; gi < LEAVES; gi++) begin : g_leaf
      if (gi < WIDTH) begin : g_real
        assign node[LEAVES-1+gi] = bits_in[gi];
      end else begin : g_pad
        assign node[LEAVES-1+gi] = 1'b0;
      end
    end
    for (gi = 0; gi < LEAVES - 1; gi++) begin : g_inner
      assign node[gi] = node[2*gi+1] ^ node[2*gi+2];
    end
  endgenerate

  assign odd_out = node[0];
endmodule

// File: rtl/par_tick_qual.sv
module par_tick_qual #(
  parameter int unsigned NUM_TICKS = 2
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic [NUM_TICKS-1:0] ticks,
  output logic                 tick_any,
  output logic                 fire
);
  logic any_prev;

  assign tick_any = |ticks;

  // held high by clear so a tick left high across release does not count
  always_ff @(posedge clk or posedge clr) begin
    if (clr) any_prev <= 1'b1;
    else     any_prev <= tick_any;
  end

  assign fire = tick_any & ~any_prev;
endmodule

// File: rtl/par_out_stage.sv
module par_out_stage
  import par_gen_pkg::*;
(
  input  logic     clk,
  input  logic     clr,
  input  logic     fire,
  input  logic     load_sel,
  input  logic     shift_sel,
  input  logic     ser_in,
  input  logic     par_in,
  output reg_src_e src,
  output logic     reg_q
);
  logic d_next;

  assign src    = pick_src(shift_sel, load_sel);
  assign d_next = next_bit(src, reg_q, par_in, ser_in);

  always_ff @(posedge clk or posedge clr) begin
    if (clr)       reg_q <= 1'b0;
    else if (fire) reg_q <= d_next;
  end
endmodule

// File: rtl/par_gen_reg.sv
module par_gen_reg
  import par_gen_pkg::*;
#(
  parameter int unsigned WIDTH = PAR_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] data_in,
  input  logic             force_low,
  input  logic             load_sel,
  input  logic             shift_sel,
  input  logic             ser_in,
  input  logic             tick_a,
  input  logic             tick_b,
  output logic             par,
  output logic             par_n,
  output logic             par_reg,
  output logic             par_reg_n
);
  localparam int unsigned NTICK = PAR_NUM_TICKS;

  logic             raw_odd;
  logic             tick_any;
  logic             fire;
  logic [NTICK-1:0] tick_vec;
  reg_src_e         src;

  par_xor_tree #(.WIDTH(WIDTH)) u_tree (
    .bits_in (data_in),
    .odd_out (raw_odd)
  );

  assign par   = gate_par(raw_odd, force_low);
  assign par_n = ~par;

  assign tick_vec = {tick_b, tick_a};

  par_tick_qual #(.NUM_TICKS(NTICK)) u_qual (
    .clk      (clk),
    .clr      (clr),
    .ticks    (tick_vec),
    .tick_any (tick_any),
    .fire     (fire)
  );

  par_out_stage u_stage (
    .clk       (clk),
    .clr       (clr),
    .fire      (fire),
    .load_sel  (load_sel),
    .shift_sel (shift_sel),
    .ser_in    (ser_in),
    .par_in    (par),
    .src       (src),
    .reg_q     (par_reg)
  );

  assign par_reg_n = ~par_reg;
endmodule

// File: rtl/par_gen_reg_chk.sv
module par_gen_reg_chk
  import par_gen_pkg::*;
#(
  parameter int unsigned WIDTH = PAR_DEF_WIDTH
) (
  input logic             clk,
  input logic             clr,
  input logic [WIDTH-1:0] data_in,
  input logic             force_low,
  input logic             load_sel,
  input logic             shift_sel,
  input logic             ser_in,
  input logic             tick_a,
  input logic             tick_b,
  input logic             par,
  input logic             par_n,
  input logic             par_reg,
  input logic             par_reg_n,
  input logic             tick_any,
  input logic             fire,
  input reg_src_e         src
);
  a_r1_odd_parity: assert property (@(posedge clk) disable iff (clr)
    !force_low |-> (par == (^data_in)));

  a_r2_force_low: assert property (@(posedge clk) disable iff (clr)
    force_low |-> !par);

  a_r3_complements: assert property (@(posedge clk) disable iff (clr)
    (par_n == !par) && (par_reg_n == !par_reg));

  a_r4_keep: assert property (@(posedge clk) disable iff (clr)
    (fire && !shift_sel && !load_sel) |=> $stable(par_reg));

  a_r5_load: assert property (@(posedge clk) disable iff (clr)
    (fire && !shift_sel && load_sel) |=> (par_reg == $past(par)));

  a_r6_shift: assert property (@(posedge clk) disable iff (clr)
    (fire && shift_sel) |=> (par_reg == $past(ser_in)));

  a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (clr)
    !fire |=> $stable(par_reg));

  a_r8_overlap_no_fire: assert property (@(posedge clk) disable iff (clr)
    $past(tick_a | tick_b) |-> !fire);

  a_r9_clear_empty: assert property (@(posedge clk)
    clr |-> !par_reg);

  a_r10_release_arm: assert property (@(posedge clk) disable iff (clr)
    $past(clr) |-> !fire);

  a_r6_src_pick: assert property (@(posedge clk) disable iff (clr)
    shift_sel |-> (src == SRC_SHIFT));

  a_r7_any_tracks: assert property (@(posedge clk) disable iff (clr)
    fire |-> tick_any);
endmodule

bind par_gen_reg par_gen_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clr       (clr),
  .data_in   (data_in),
  .force_low (force_low),
  .load_sel  (load_sel),
  .shift_sel (shift_sel),
  .ser_in    (ser_in),
  .tick_a    (tick_a),
  .tick_b    (tick_b),
  .par       (par),
  .par_n     (par_n),
  .par_reg   (par_reg),
  .par_reg_n (par_reg_n),
  .tick_any  (tick_any),
  .fire      (fire),
  .src       (src)
);

// File: tb/par_gen_reg_test.sv
`timescale 1ns/1ps
module par_gen_reg_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         clr;
  logic [W-1:0] data_in;
  logic         force_low, load_sel, shift_sel, ser_in, tick_a, tick_b;
  logic         par, par_n, par_reg, par_reg_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model state
  logic m_reg, m_prev, m_after_clr, p_ta, p_tb;

  always #2 clk = ~clk;

  par_gen_reg #(.WIDTH(W)) uut (
    .clk(clk), .clr(clr), .data_in(data_in), .force_low(force_low),
    .load_sel(load_sel), .shift_sel(shift_sel), .ser_in(ser_in),
    .tick_a(tick_a), .tick_b(tick_b), .par(par), .par_n(par_n),
    .par_reg(par_reg), .par_reg_n(par_reg_n)
  );

  function automatic logic exp_par(input logic [W-1:0] v, input logic f);
    int cnt = 0;
    for (int i = 0; i < W; i++) cnt += int'(v[i]);
    return (f == 1'b0) && (cnt % 2 == 1);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic [W-1:0] d, input logic f, input logic ld,
                       input logic sh, input logic si, input logic ta,
                       input logic tb, input logic c);
    string tag;
    logic  orv, pe;
    @(negedge clk);
    data_in = d; force_low = f; load_sel = ld; shift_sel = sh;
    ser_in = si; tick_a = ta; tick_b = tb; clr = c;
    #1;
    pe = exp_par(d, f);
    check(f ? "R2 par forced" : "R1 par", par, pe);
    check("R3 par_n", par_n, ~pe);
    if (c) begin
      m_reg = 1'b0; m_prev = 1'b1; m_after_clr = 1'b1;
      check("R9 async clear", par_reg, 1'b0);
    end
    @(posedge clk);
    orv = ta | tb;
    if (c) begin
      tag = "R9 clear holds";
      m_reg = 1'b0; m_prev = 1'b1; m_after_clr = 1'b1;
    end else begin
      if (orv && !m_prev) begin
        if (sh)      begin tag = "R6 shift"; m_reg = si; end
        else if (ld) begin tag = "R5 load";  m_reg = pe; end
        else         tag = "R4 keep";
      end else if (m_after_clr && orv) tag = "R10 release armed";
      else if (orv && ((ta && !p_ta) || (tb && !p_tb))) tag = "R8 overlap rise";
      else tag = "R7 no qualified tick";
      if (!orv) m_after_clr = 1'b0;
      m_prev = orv;
    end
    p_ta = ta; p_tb = tb;
    #1;
    check(tag, par_reg, m_reg);
    check("R3 par_reg_n", par_reg_n, ~m_reg);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clr = 1'b1; data_in = '0; force_low = 1'b0; load_sel = 1'b0;
    shift_sel = 1'b0; ser_in = 1'b0; tick_a = 1'b0; tick_b = 1'b0;
    m_reg = 1'b0; m_prev = 1'b1; m_after_clr = 1'b1; p_ta = 1'b0; p_tb = 1'b0;

    // reset state and clear overriding ticks (R9)
    cycle(12'h001, 0, 1, 0, 0, 0, 0, 1);
    cycle(12'h001, 0, 1, 0, 0, 1, 0, 1);
    cycle(12'h001, 0, 1, 1, 1, 0, 1, 1);
    // R10: tick held high across release does not update
    cycle(12'h001, 0, 1, 0, 0, 1, 0, 1);
    cycle(12'h001, 0, 1, 0, 0, 1, 0, 0);
    cycle(12'h001, 0, 1, 0, 0, 0, 0, 0);
    // R5: load odd parity -> 1
    cycle(12'h007, 0, 1, 0, 0, 1, 0, 0);
    // R8: b rises while a still high
    cycle(12'h000, 0, 1, 0, 0, 1, 1, 0);
    cycle(12'h000, 0, 1, 0, 0, 0, 0, 0);
    // R4: keep
    cycle(12'h000, 0, 0, 0, 0, 0, 1, 0);
    cycle(12'h000, 0, 0, 0, 0, 0, 0, 0);
    // R5 with force high: loads 0 (R2 gating)
    cycle(12'hFFE, 1, 1, 0, 1, 1, 1, 0);
    cycle(12'h000, 0, 0, 0, 0, 0, 0, 0);
    // R6: shift wins over load
    cycle(12'h000, 0, 1, 1, 1, 1, 0, 0);
    cycle(12'h000, 0, 1, 1, 0, 0, 0, 0);
    cycle(12'hFFF, 0, 1, 1, 0, 0, 1, 0);
    cycle(12'h800, 0, 0, 0, 0, 0, 0, 0);
    // R1: all-ones and single-bit patterns
    cycle(12'hFFF, 0, 0, 0, 0, 0, 0, 0);
    cycle(12'h800, 0, 0, 0, 0, 0, 0, 0);
    // R9: clear and qualified tick in the same cycle
    cycle(12'h001, 0, 1, 0, 0, 0, 0, 0);
    cycle(12'h001, 0, 1, 0, 0, 1, 0, 0);
    cycle(12'h001, 0, 1, 0, 0, 0, 0, 0);
    cycle(12'h001, 0, 1, 0, 0, 1, 0, 1);
    cycle(12'h001, 0, 1, 0, 0, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      cycle(W'($urandom), ($urandom % 4) == 0, $urandom % 2, ($urandom % 3) == 0,
            $urandom % 2, ($urandom % 10) < 3, ($urandom % 10) < 3,
            ($urandom % 40) == 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule